// File: doc/BRIEF.md
# Multiplexed DRAM Pin-Interface Responder

This block acts as the device end of a fast page mode DRAM with a multiplexed address bus. It is meant to stand in for a real memory behind a DRAM controller under test. It runs on a sampling clock much faster than the strobes and finds strobe edges by comparing each strobe with its value at the previous clock edge. The row half of the word index is taken at the row strobe fall, and the column half at the column strobe fall. Reads and writes go to an internal array of `2^(2*ADDR_W)` words of `DATA_W` bits. The array geometry is a parameter. A full 256-row device sets `ADDR_W` to 8; the default is a small 32 x 32 array.

The output-drive flag depends on the kind of cycle:
- A write that is set up before the column strobe falls never drives the bus.
- A read, or an access whose write strobe falls after the column strobe, drives the bus after a programmable delay.
- The driven value stays on the bus while the column strobe is held low, even after the row strobe has gone high.

While the column strobe is still held, a new row strobe pulse refreshes a row and opens it for further accesses. A tracker keeps one age counter per row and raises a sticky flag when any row has gone too long without a row strobe.

The controller is a state machine with seven states:
- IDLE: no row open.
- ROW_OPEN: row latched, column strobe high.
- READ: column access with the write strobe high.
- WRITE_CAS: write taken at the column strobe fall.
- WRITE_LATE: the write strobe fell inside a read access.
- HOLD: row strobe high, column strobe still low, output held.
- HIDDEN: row strobe low again under a held column strobe.

Transitions:
- IDLE to ROW_OPEN, or to HIDDEN when the column strobe is already low, on a row fall.
- ROW_OPEN to READ or WRITE_CAS on a column fall, and back to IDLE on a row rise.
- READ to WRITE_LATE on a write-strobe fall.
- READ, WRITE_CAS, WRITE_LATE and HIDDEN to HOLD on a row rise.
- HOLD to HIDDEN on a row fall.
- Any state with the column strobe low leaves on a column rise, to ROW_OPEN if the row strobe is low and to IDLE otherwise.

Top module: `dram_pin_responder`

## Requirements
- R1: A row strobe fall latches `mux_addr` as the row. A column strobe fall while the row strobe is low latches `mux_addr` as the column. The word index is `{row, column}`, with the row in the upper half.
- R2: When the write strobe is high at the column strobe fall, the cycle is a read. `rdata` then presents the word stored at the index.
- R3: When the write strobe is low at the column strobe fall, `wdata` is written at that edge. `rdata_drive` stays low for the whole cycle, even with the output gate low.
- R4: When the write strobe falls during a read access, `wdata` is written to the latched column at that edge. `rdata_drive` still turns on after the delay and shows the word that was read at the column fall.
- R5: At the first clock edge that samples the column strobe high, the output drive is off. It stays off while the column strobe remains high.
- R6: `rdata_drive` turns on at the ACCESS_DLY-th clock edge after the edge that first samples the column strobe low, provided the output gate is low.
- R7: After a read, `rdata_drive` and `rdata` are held while the column strobe stays low, even when the row strobe rises. A new row strobe fall in that state latches and refreshes a new row. A later column strobe rise with the row strobe low leaves that new row open for accesses.
- R8: Several column strobe pulses inside one row strobe low period access several columns of the same row.
- R9: A row strobe pulse with the column strobe kept high changes no stored word and never drives the output.
- R10: A column strobe fall while the row strobe is high is ignored. Nothing is written and the output is not driven.
- R11: `rdata_drive` is high only while the internal data-valid state is set and `out_gate_n` is low. Raising the gate turns the drive off at once.
- R12: Each row has an age counter that advances once per clock edge and is cleared by a row strobe fall on that row. `refresh_error` is set one edge after any counter reaches REFRESH_LIMIT. It stays set until reset.
- R13: After reset, all strobes are treated as high, the state is IDLE, `rdata_drive` is low and `refresh_error` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_stb_n | input | 1 | Row address strobe, active low |
| col_stb_n | input | 1 | Column address strobe, active low |
| wr_stb_n | input | 1 | Write strobe, active low (high selects read) |
| out_gate_n | input | 1 | Output gate, active low |
| mux_addr | input | ADDR_W | Multiplexed row/column address |
| wdata | input | DATA_W | Data written into the array |
| rdata | output | DATA_W | Word read from the array |
| rdata_drive | output | 1 | High when the data bus is to be driven |
| refresh_error | output | 1 | Sticky flag for a row left unrefreshed too long |

## Verification
The first pattern fills every cell with column-controlled writes in page mode, using a value computed from the row and column. It then reads every cell back in page mode. This separates errors in row and column latching from errors in write or read timing, and shows that writes leave the output undriven.

Directed sequences then cover the remaining cycle types:
- Single accesses held several edges, to pin the exact edge where the drive turns on and to exercise the output gate.
- A late write, to show that old data is driven while new data is stored.
- A held column strobe across a row strobe rise and a new fall, to distinguish holding the output from hidden refresh with a new row.
- A row-only pulse, and a column strobe with the row strobe high, to show that neither disturbs stored data.

The refresh flag is tested in two ways. With no refresh at all, the bench checks the exact edge at which the flag rises. With a round-robin of row pulses, the bench checks that the flag stays clear, and then that it stays set once raised.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_OPEN,
        ST_READ,
        ST_WRITE_CAS,
        ST_WRITE_LATE,
        ST_HOLD,
        ST_HIDDEN
    } acc_state_e;

    typedef struct packed {
        logic row_fall;
        logic row_rise;
        logic col_fall;
        logic col_rise;
        logic wr_fall;
    } strobe_ev_t;

endpackage

// File: rtl/dpr_strobe_sampler.sv
module dpr_strobe_sampler
    import dpr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       row_stb_n,
    input  logic       col_stb_n,
    input  logic       wr_stb_n,
    output strobe_ev_t ev,
    output logic       row_lvl,
    output logic       col_lvl
);

    logic wr_lvl;

    // Previous strobe levels; all strobes read as inactive (high) out of reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_lvl <= 1'b1;
            col_lvl <= 1'b1;
            wr_lvl  <= 1'b1;
        end else begin
            row_lvl <= row_stb_n;
            col_lvl <= col_stb_n;
            wr_lvl  <= wr_stb_n;
        end
    end

    always_comb begin
        ev.row_fall = row_lvl  & ~row_stb_n;
        ev.row_rise = ~row_lvl & row_stb_n;
        ev.col_fall = col_lvl  & ~col_stb_n;
        ev.col_rise = ~col_lvl & col_stb_n;
        ev.wr_fall  = wr_lvl   & ~wr_stb_n;
    end

endmodule

// File: rtl/dpr_cell_array.sv
module dpr_cell_array #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 4
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [2*ADDR_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [2*ADDR_W-1:0]   rd_idx,
    output logic [DATA_W-1:0]     rd_data
);

    localparam int IDX_W = 2 * ADDR_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_data;
        end
    end

    assign rd_data = cells[rd_idx];

endmodule

// File: rtl/dpr_refresh_tracker.sv
module dpr_refresh_tracker #(
    parameter int ADDR_W        = 5,
    parameter int REFRESH_LIMIT = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refresh_en,
    input  logic [ADDR_W-1:0] refresh_row,
    output logic              refresh_error
);

    localparam int NUM_ROWS = 1 << ADDR_W;
    localparam int CNT_W    = $clog2(REFRESH_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(REFRESH_LIMIT);

    logic [NUM_ROWS-1:0] stale;

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row_age
        logic [CNT_W-1:0] age;

        // Saturating age counter, cleared by a row strobe on this row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                age <= '0;
            end else if (refresh_en && refresh_row == ADDR_W'(g)) begin
                age <= '0;
            end else if (age != LIMIT_C) begin
                age <= age + 1'b1;
            end
        end

        assign stale[g] = (age == LIMIT_C);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            refresh_error <= 1'b0;
        end else if (|stale) begin
            refresh_error <= 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_error |=> refresh_error); // R12

endmodule

// File: rtl/dpr_access_fsm.sv
module dpr_access_fsm
    import dpr_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 4,
    parameter int ACCESS_DLY = 2   // must be at least 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  strobe_ev_t          ev,
    input  logic                row_lvl,
    input  logic                col_lvl,
    input  logic                row_stb_n,
    input  logic                col_stb_n,
    input  logic                wr_stb_n,
    input  logic [ADDR_W-1:0]   mux_addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   cell_rdata,
    output logic                cell_we,
    output logic [2*ADDR_W-1:0] cell_widx,
    output logic [DATA_W-1:0]   cell_wdata,
    output logic [2*ADDR_W-1:0] cell_ridx,
    output logic [DATA_W-1:0]   rd_hold,
    output logic                data_valid,
    output logic                refresh_en,
    output logic [ADDR_W-1:0]   refresh_row
);

    localparam int DLY_W = (ACCESS_DLY < 2) ? 1 : $clog2(ACCESS_DLY + 1);

    acc_state_e        state, state_nx, after_col;
    logic [ADDR_W-1:0] row_lat;
    logic [ADDR_W-1:0] col_lat;
    logic              armed;
    logic [DLY_W-1:0]  dly_cnt;
    logic              go_read, go_cwrite, go_late;

    // Cycle decode
    assign after_col = row_stb_n ? ST_IDLE : ST_ROW_OPEN;
    assign go_read   = (state == ST_ROW_OPEN) && !ev.row_rise && ev.col_fall &&  wr_stb_n;
    assign go_cwrite = (state == ST_ROW_OPEN) && !ev.row_rise && ev.col_fall && !wr_stb_n;
    assign go_late   = (state == ST_READ) && !ev.col_rise && !ev.row_rise && ev.wr_fall;

    assign cell_we     = go_cwrite | go_late;
    assign cell_widx   = go_late ? {row_lat, col_lat} : {row_lat, mux_addr};
    assign cell_wdata  = wdata;
    assign cell_ridx   = {row_lat, mux_addr};
    assign refresh_en  = ev.row_fall;
    assign refresh_row = mux_addr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ev.row_fall) begin
                    state_nx = col_stb_n ? ST_ROW_OPEN : ST_HIDDEN;
                end
            end
            ST_ROW_OPEN: begin
                if (ev.row_rise) begin
                    state_nx = ST_IDLE;
                end else if (ev.col_fall) begin
                    state_nx = wr_stb_n ? ST_READ : ST_WRITE_CAS;
                end
            end
            ST_READ: begin
                if (ev.col_rise) begin
                    state_nx = after_col;
                end else if (ev.row_rise) begin
                    state_nx = ST_HOLD;
                end else if (ev.wr_fall) begin
                    state_nx = ST_WRITE_LATE;
                end
            end
            ST_WRITE_CAS, ST_WRITE_LATE, ST_HIDDEN: begin
                if (ev.col_rise) begin
                    state_nx = after_col;
                end else if (ev.row_rise) begin
                    state_nx = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (ev.col_rise) begin
                    state_nx = after_col;
                end else if (ev.row_fall) begin
                    state_nx = ST_HIDDEN;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Registered outputs: latched addresses, read data and the access timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_lat    <= '0;
            col_lat    <= '0;
            rd_hold    <= '0;
            data_valid <= 1'b0;
            armed      <= 1'b0;
            dly_cnt    <= '0;
        end else begin
            if (refresh_en) begin
                row_lat <= mux_addr;
            end
            if (go_read || go_cwrite) begin
                col_lat <= mux_addr;
            end
            if (go_read) begin
                rd_hold <= cell_rdata;
                armed   <= 1'b1;
                dly_cnt <= DLY_W'(ACCESS_DLY - 1);
            end else if (ev.col_rise) begin
                data_valid <= 1'b0;
                armed      <= 1'b0;
            end else if (armed) begin
                if (dly_cnt == '0) begin
                    data_valid <= 1'b1;
                    armed      <= 1'b0;
                end else begin
                    dly_cnt <= dly_cnt - 1'b1;
                end
            end
        end
    end

    AST_FLOAT_CAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        col_stb_n |=> !data_valid); // R5
    AST_CASWR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE_CAS) |-> !data_valid); // R3
    AST_ACCESS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_READ, ST_WRITE_CAS, ST_WRITE_LATE}) |-> (!row_lvl && !col_lvl)); // R1
    AST_HOLD_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (row_lvl && !col_lvl)); // R7
    AST_ROW_OPEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROW_OPEN) |-> (!row_lvl && col_lvl)); // R8
    AST_WRITE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        cell_we |-> (!row_stb_n && !col_stb_n)); // R4

endmodule

// File: rtl/dram_pin_responder.sv
module dram_pin_responder
    import dpr_pkg::*;
#(
    parameter int ADDR_W        = 5,
    parameter int DATA_W        = 4,
    parameter int ACCESS_DLY    = 2,
    parameter int REFRESH_LIMIT = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_stb_n,
    input  logic              col_stb_n,
    input  logic              wr_stb_n,
    input  logic              out_gate_n,
    input  logic [ADDR_W-1:0] mux_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drive,
    output logic              refresh_error
);

    localparam int IDX_W = 2 * ADDR_W;

    strobe_ev_t        ev;
    logic              row_lvl, col_lvl;
    logic              cell_we;
    logic [IDX_W-1:0]  cell_widx, cell_ridx;
    logic [DATA_W-1:0] cell_wdata, cell_rdata;
    logic              data_valid;
    logic              refresh_en;
    logic [ADDR_W-1:0] refresh_row;

    dpr_strobe_sampler u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_stb_n (row_stb_n),
        .col_stb_n (col_stb_n),
        .wr_stb_n  (wr_stb_n),
        .ev        (ev),
        .row_lvl   (row_lvl),
        .col_lvl   (col_lvl)
    );

    dpr_access_fsm #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .ACCESS_DLY (ACCESS_DLY)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .row_lvl     (row_lvl),
        .col_lvl     (col_lvl),
        .row_stb_n   (row_stb_n),
        .col_stb_n   (col_stb_n),
        .wr_stb_n    (wr_stb_n),
        .mux_addr    (mux_addr),
        .wdata       (wdata),
        .cell_rdata  (cell_rdata),
        .cell_we     (cell_we),
        .cell_widx   (cell_widx),
        .cell_wdata  (cell_wdata),
        .cell_ridx   (cell_ridx),
        .rd_hold     (rdata),
        .data_valid  (data_valid),
        .refresh_en  (refresh_en),
        .refresh_row (refresh_row)
    );

    dpr_cell_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (cell_we),
        .wr_idx  (cell_widx),
        .wr_data (cell_wdata),
        .rd_idx  (cell_ridx),
        .rd_data (cell_rdata)
    );

    dpr_refresh_tracker #(
        .ADDR_W        (ADDR_W),
        .REFRESH_LIMIT (REFRESH_LIMIT)
    ) u_refresh (
        .clk           (clk),
        .rst_n         (rst_n),
        .refresh_en    (refresh_en),
        .refresh_row   (refresh_row),
        .refresh_error (refresh_error)
    );

    assign rdata_drive = data_valid & ~out_gate_n;

endmodule

// File: tb/dram_pin_responder_bench.sv
module dram_pin_responder_bench;

    localparam int AW  = 5;
    localparam int DW  = 4;
    localparam int DLY = 3;
    localparam int LIM = 300;
    localparam int NR  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          row_stb_n = 1'b1, col_stb_n = 1'b1, wr_stb_n = 1'b1, out_gate_n = 1'b0;
    logic [AW-1:0] mux_addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_drive, refresh_error;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [NR*NR];

    always #5 clk = ~clk;

    dram_pin_responder #(
        .ADDR_W(AW), .DATA_W(DW), .ACCESS_DLY(DLY), .REFRESH_LIMIT(LIM)
    ) u_dram_pin_responder (
        .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
        .wr_stb_n(wr_stb_n), .out_gate_n(out_gate_n), .mux_addr(mux_addr),
        .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive),
        .refresh_error(refresh_error)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int r, input int c);
        return DW'(r * 5 + c * 3 + 1);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        row_stb_n = 1'b1; col_stb_n = 1'b1; wr_stb_n = 1'b1; out_gate_n = 1'b0;
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
    endtask

    task automatic open_row(input int r);
        mux_addr = AW'(r); row_stb_n = 1'b0; tick();
    endtask

    task automatic close_row();
        row_stb_n = 1'b1; tick();
    endtask

    task automatic write_col(input int r, input int c, input logic [DW-1:0] d);
        mux_addr = AW'(c); wdata = d; wr_stb_n = 1'b0; col_stb_n = 1'b0; tick();
        check("R3 write no drive", rdata_drive, 1'b0);
        model[r*NR+c] = d;
        col_stb_n = 1'b1; wr_stb_n = 1'b1; tick();
    endtask

    task automatic read_col(input int c, output logic [DW-1:0] d, output logic oe);
        mux_addr = AW'(c); wr_stb_n = 1'b1; col_stb_n = 1'b0;
        repeat (DLY + 1) tick();
        d = rdata; oe = rdata_drive;
        col_stb_n = 1'b1; tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d, old;
        logic          oe;

        // R13 reset state
        do_reset();
        check("R13 drive after reset", rdata_drive, 1'b0);
        check("R13 error after reset", refresh_error, 1'b0);

        // R12 exact edge at which the flag rises with no refresh at all
        do_reset();
        repeat (LIM) tick();
        check("R12 flag before limit", refresh_error, 1'b0);
        tick();
        check("R12 flag at limit", refresh_error, 1'b1);
        for (int r = 0; r < NR; r++) begin open_row(r); close_row(); end
        check("R12 flag sticky", refresh_error, 1'b1);

        // R12 round-robin refresh keeps the flag clear
        do_reset();
        for (int k = 0; k < 6; k++) begin
            for (int r = 0; r < NR; r++) begin open_row(r); close_row(); end
        end
        check("R12 refreshed rows no flag", refresh_error, 1'b0);

        // R1 R3 R8 fill in page mode, then R2 R8 read back
        do_reset();
        for (int r = 0; r < NR; r++) begin
            open_row(r);
            for (int c = 0; c < NR; c++) write_col(r, c, pat(r, c));
            close_row();
        end
        for (int r = 0; r < NR; r++) begin
            open_row(r);
            for (int c = 0; c < NR; c++) begin
                read_col(c, d, oe);
                check("R2 R8 read data", d, model[r*NR+c]);
                check("R1 read drive", oe, 1'b1);
            end
            close_row();
        end

        // R6 delay edge, R11 gate, R5 column strobe high
        open_row(3);
        mux_addr = AW'(7); wr_stb_n = 1'b1; col_stb_n = 1'b0;
        repeat (DLY) tick();
        check("R6 drive before delay", rdata_drive, 1'b0);
        tick();
        check("R6 drive at delay", rdata_drive, 1'b1);
        check("R6 data", rdata, model[3*NR+7]);
        out_gate_n = 1'b1; tick();
        check("R11 gate high", rdata_drive, 1'b0);
        out_gate_n = 1'b0; tick();
        check("R11 gate low", rdata_drive, 1'b1);
        col_stb_n = 1'b1; tick();
        check("R5 column high", rdata_drive, 1'b0);
        close_row();

        // R3 long column-controlled write never drives
        open_row(4);
        mux_addr = AW'(9); wdata = ~model[4*NR+9]; wr_stb_n = 1'b0; col_stb_n = 1'b0;
        model[4*NR+9] = ~model[4*NR+9];
        for (int k = 0; k < DLY + 2; k++) begin
            tick();
            check("R3 held write no drive", rdata_drive, 1'b0);
        end
        col_stb_n = 1'b1; wr_stb_n = 1'b1; tick();
        read_col(9, d, oe);
        check("R3 written value", d, model[4*NR+9]);
        close_row();

        // R4 late write: old data driven, new data stored
        open_row(6);
        old = model[6*NR+2];
        mux_addr = AW'(2); wr_stb_n = 1'b1; col_stb_n = 1'b0; tick();
        wr_stb_n = 1'b0; wdata = old ^ 4'h5; mux_addr = AW'(30); tick();
        model[6*NR+2] = old ^ 4'h5;
        repeat (DLY - 1) tick();
        check("R4 late write drive", rdata_drive, 1'b1);
        check("R4 late write old data", rdata, old);
        col_stb_n = 1'b1; wr_stb_n = 1'b1; tick();
        read_col(2, d, oe);
        check("R4 late write stored", d, model[6*NR+2]);
        read_col(30, d, oe);
        check("R4 other column untouched", d, model[6*NR+30]);
        close_row();

        // R7 hold across row rise, hidden refresh with new row
        open_row(8);
        mux_addr = AW'(5); wr_stb_n = 1'b1; col_stb_n = 1'b0;
        repeat (DLY + 1) tick();
        row_stb_n = 1'b1; tick();
        check("R7 hold drive", rdata_drive, 1'b1);
        check("R7 hold data", rdata, model[8*NR+5]);
        mux_addr = AW'(11); row_stb_n = 1'b0; tick();
        check("R7 hidden drive", rdata_drive, 1'b1);
        check("R7 hidden data", rdata, model[8*NR+5]);
        col_stb_n = 1'b1; tick();
        check("R5 after hidden", rdata_drive, 1'b0);
        read_col(13, d, oe);
        check("R7 new row open", d, model[11*NR+13]);
        close_row();

        // R5 column rise with row strobe already high
        open_row(9);
        mux_addr = AW'(1); col_stb_n = 1'b0; repeat (DLY + 1) tick();
        row_stb_n = 1'b1; tick();
        col_stb_n = 1'b1; tick();
        check("R5 column rise after row", rdata_drive, 1'b0);

        // R9 row-only refresh
        open_row(12);
        repeat (3) begin
            tick();
            check("R9 no drive", rdata_drive, 1'b0);
        end
        close_row();
        open_row(12);
        for (int c = 0; c < 4; c++) begin
            read_col(c, d, oe);
            check("R9 data kept", d, model[12*NR+c]);
        end
        close_row();

        // R10 column strobe with row strobe high
        mux_addr = AW'(4); wdata = ~model[12*NR+4]; wr_stb_n = 1'b0; col_stb_n = 1'b0;
        repeat (DLY + 1) tick();
        check("R10 no drive", rdata_drive, 1'b0);
        col_stb_n = 1'b1; wr_stb_n = 1'b1; tick();
        open_row(12);
        read_col(4, d, oe);
        check("R10 no write", d, model[12*NR+4]);
        close_row();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule